// File: doc/BRIEF.md
# Access Permission Check Cache

This block decides whether a memory access may read, write or execute, once the address has been translated. Each translation entry carries a 16-bit access-list identifier, loaded with the address mapping. The current keyring register carries a 16-bit key in its low bits. The pair (list identifier, key) is looked up in a small, fully associative cache. The cache holds the rights that software has granted for that pair.

A lookup resolves combinationally in the cycle it is presented. On a hit the stored read, write and execute rights appear at the outputs. On a miss a fault is raised and every right is denied until software installs the pair through the fill port. Software can also flush every entry that belongs to one list identifier. Rights that software changes for a list then apply to every page already mapped, with no need to touch the translation buffer. When the key field of the keyring is zero, checking is switched off and the access is left unrestricted.

Top module: `acl_check_cache`

## Requirements
- R1: After reset every entry is invalid. A lookup with a nonzero key then reports a fault and no hit.
- R2: A lookup whose (list identifier, key) pair is held in a valid entry asserts `lk_hit` in the same cycle. It drives the stored rights, where rights bit 2 is read, bit 1 is write and bit 0 is execute, onto `lk_read`, `lk_write` and `lk_exec`.
- R3: A lookup with a nonzero key that matches no valid entry asserts `lk_fault`, deasserts `lk_hit`, and drives all three rights low.
- R4: When bits 15:0 of `lk_keyring` are zero, a lookup drives all three rights high and `lk_fault` and `lk_hit` low, whatever the cache holds and whatever the upper keyring bits are.
- R5: A fill of a pair that is not present writes the lowest-numbered invalid entry.
- R6: A fill of a pair that is not present, when all entries are valid, replaces the entry named by a round-robin pointer. The pointer is 0 after reset, advances by one on each such replacement, and wraps after the last entry.
- R7: A fill of a pair already present rewrites the rights of that entry in place. It allocates nothing and leaves the pointer unchanged.
- R8: A flush clears every valid entry whose list identifier equals `flush_list_id`, whatever its key. The effect is visible from the next cycle. A lookup in the flush cycle still sees the old contents.
- R9: A lookup presented in the same cycle as a fill sees the contents from before the fill.
- R10: When a fill and a flush occur in the same cycle, the entry written by the fill is valid afterwards, even if its list identifier is the flushed one. The flush still clears the other matching entries. The fill target is chosen from the contents before the flush.
- R11: With `lk_valid` low, `lk_hit`, `lk_fault` and all three rights are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_list_id | input | 16 | Access-list identifier from the translation entry |
| lk_keyring | input | 32 | Keyring register value; bits 15:0 form the key |
| lk_hit | output | 1 | Pair found in the cache |
| lk_fault | output | 1 | Pair missing; software must fill it |
| lk_read | output | 1 | Read permitted |
| lk_write | output | 1 | Write permitted |
| lk_exec | output | 1 | Execute permitted |
| fill_en | input | 1 | Install or update an entry |
| fill_list_id | input | 16 | List identifier of the entry to install |
| fill_key | input | 16 | Key of the entry to install |
| fill_perm | input | 3 | Rights to install (bit 2 read, bit 1 write, bit 0 execute) |
| flush_en | input | 1 | Flush request |
| flush_list_id | input | 16 | List identifier whose entries are cleared |

## Verification
The assertions check on every cycle the relations that hold at the ports. A fault never coincides with a hit or with any granted right. A disabled key always opens the access, and an idle port stays quiet. A pair filled in one cycle hits with its rights in the next, and a flushed list misses in the cycle after the flush. Only the bench scenarios can show which entry a fill lands in and which one the round-robin pointer evicts. The same holds for the in-place update of an existing pair and for the exact cycle boundary of fills and flushes against a concurrent lookup. The bench observes these through later lookups, compared against a reference model of the requirements.

// File: rtl/acl_pkg.sv
package acl_pkg;

    localparam int LIST_ID_W = 16;
    localparam int KEY_W     = 16;
    localparam int PERM_W    = 3;

    localparam int PERM_RD = 2;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 0;

    typedef struct packed {
        logic                 valid;
        logic [LIST_ID_W-1:0] list_id;
        logic [KEY_W-1:0]     key;
        logic [PERM_W-1:0]    perm;
    } acl_entry_t;

endpackage

// File: rtl/acl_match.sv
module acl_match
    import acl_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  acl_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [LIST_ID_W-1:0]         list_id,
    input  logic [KEY_W-1:0]             key,
    output logic [NUM_ENTRIES-1:0]       match_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic [PERM_W-1:0]            hit_perm
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = entries[g].valid
                            && (entries[g].list_id == list_id)
                            && (entries[g].key == key);
    end

    always_comb begin
        hit      = |match_vec;
        hit_idx  = '0;
        hit_perm = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx  = IDX_W'(i);
                hit_perm = hit_perm | entries[i].perm;
            end
        end
    end

endmodule

// File: rtl/acl_victim.sv
module acl_victim #(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic [IDX_W-1:0]       rr_ptr,
    output logic [IDX_W-1:0]       victim_idx,
    output logic                   all_valid
);

    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
            end
        end
        all_valid  = &valid_vec;
        victim_idx = all_valid ? rr_ptr : free_idx;
    end

endmodule

// File: rtl/acl_store.sv
module acl_store
    import acl_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  acl_entry_t                   wr_entry,
    input  logic                         ptr_adv,
    input  logic                         flush_en,
    input  logic [LIST_ID_W-1:0]         flush_list_id,
    output acl_entry_t [NUM_ENTRIES-1:0] entries,
    output logic [NUM_ENTRIES-1:0]       valid_vec,
    output logic [IDX_W-1:0]             rr_ptr
);

    typedef struct packed {
        acl_entry_t [NUM_ENTRIES-1:0] ent;
        logic [IDX_W-1:0]             ptr;
    } store_state_t;

    store_state_t st_d;
    store_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (flush_en) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (st_q.ent[i].list_id == flush_list_id) begin
                    st_d.ent[i].valid = 1'b0;
                end
            end
        end
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_entry;
        end
        if (ptr_adv) begin
            if (st_q.ptr == IDX_W'(NUM_ENTRIES - 1)) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries = st_q.ent;
    assign rr_ptr  = st_q.ptr;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = st_q.ent[g].valid;
    end

endmodule

// File: rtl/acl_check_cache.sv
module acl_check_cache
    import acl_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int KEYRING_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [LIST_ID_W-1:0] lk_list_id,
    input  logic [KEYRING_W-1:0] lk_keyring,
    output logic                 lk_hit,
    output logic                 lk_fault,
    output logic                 lk_read,
    output logic                 lk_write,
    output logic                 lk_exec,
    input  logic                 fill_en,
    input  logic [LIST_ID_W-1:0] fill_list_id,
    input  logic [KEY_W-1:0]     fill_key,
    input  logic [PERM_W-1:0]    fill_perm,
    input  logic                 flush_en,
    input  logic [LIST_ID_W-1:0] flush_list_id
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    acl_entry_t [NUM_ENTRIES-1:0] entries;
    logic [NUM_ENTRIES-1:0]       valid_vec;
    logic [IDX_W-1:0]             rr_ptr;

    logic [KEY_W-1:0]       lk_key;
    logic                   lk_bypass;
    logic [NUM_ENTRIES-1:0] lk_match_vec;
    logic                   lk_found;
    logic [IDX_W-1:0]       lk_idx;
    logic [PERM_W-1:0]      lk_perm;

    logic [NUM_ENTRIES-1:0] fl_match_vec;
    logic                   fl_found;
    logic [IDX_W-1:0]       fl_idx;
    logic [PERM_W-1:0]      fl_perm;

    logic [IDX_W-1:0] victim_idx;
    logic             all_valid;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    acl_entry_t       wr_entry;
    logic             ptr_adv;

    assign lk_key    = lk_keyring[KEY_W-1:0];
    assign lk_bypass = (lk_key == '0);

    acl_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_match (
        .entries   (entries),
        .list_id   (lk_list_id),
        .key       (lk_key),
        .match_vec (lk_match_vec),
        .hit       (lk_found),
        .hit_idx   (lk_idx),
        .hit_perm  (lk_perm)
    );

    acl_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_fl_match (
        .entries   (entries),
        .list_id   (fill_list_id),
        .key       (fill_key),
        .match_vec (fl_match_vec),
        .hit       (fl_found),
        .hit_idx   (fl_idx),
        .hit_perm  (fl_perm)
    );

    acl_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .valid_vec  (valid_vec),
        .rr_ptr     (rr_ptr),
        .victim_idx (victim_idx),
        .all_valid  (all_valid)
    );

    always_comb begin
        wr_en            = fill_en;
        wr_idx           = fl_found ? fl_idx : victim_idx;
        wr_entry.valid   = 1'b1;
        wr_entry.list_id = fill_list_id;
        wr_entry.key     = fill_key;
        wr_entry.perm    = fill_perm;
        ptr_adv          = fill_en && !fl_found && all_valid;
    end

    acl_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_entry      (wr_entry),
        .ptr_adv       (ptr_adv),
        .flush_en      (flush_en),
        .flush_list_id (flush_list_id),
        .entries       (entries),
        .valid_vec     (valid_vec),
        .rr_ptr        (rr_ptr)
    );

    always_comb begin
        lk_hit   = 1'b0;
        lk_fault = 1'b0;
        lk_read  = 1'b0;
        lk_write = 1'b0;
        lk_exec  = 1'b0;
        if (lk_valid) begin
            if (lk_bypass) begin
                lk_read  = 1'b1;
                lk_write = 1'b1;
                lk_exec  = 1'b1;
            end else if (lk_found) begin
                lk_hit   = 1'b1;
                lk_read  = lk_perm[PERM_RD];
                lk_write = lk_perm[PERM_WR];
                lk_exec  = lk_perm[PERM_EX];
            end else begin
                lk_fault = 1'b1;
            end
        end
    end

endmodule

// File: rtl/acl_check_cache_chk.sv
module acl_check_cache_chk
    import acl_pkg::*;
#(
    parameter int KEYRING_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lk_valid,
    input logic [LIST_ID_W-1:0] lk_list_id,
    input logic [KEYRING_W-1:0] lk_keyring,
    input logic                 lk_hit,
    input logic                 lk_fault,
    input logic                 lk_read,
    input logic                 lk_write,
    input logic                 lk_exec,
    input logic                 fill_en,
    input logic [LIST_ID_W-1:0] fill_list_id,
    input logic [KEY_W-1:0]     fill_key,
    input logic [PERM_W-1:0]    fill_perm,
    input logic                 flush_en,
    input logic [LIST_ID_W-1:0] flush_list_id
);

    logic [KEY_W-1:0] key_now;
    logic             live_prev;

    assign key_now = lk_keyring[KEY_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_prev <= 1'b0;
        end else begin
            live_prev <= 1'b1;
        end
    end

    AST_FAULT_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> !lk_hit && !lk_read && !lk_write && !lk_exec); // R3

    AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && key_now == '0) |-> lk_read && lk_write && lk_exec && !lk_fault && !lk_hit); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit && !lk_fault && !lk_read && !lk_write && !lk_exec); // R11

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_prev && $past(fill_en) && lk_valid && key_now != '0
         && lk_list_id == $past(fill_list_id) && key_now == $past(fill_key))
        |-> lk_hit && {lk_read, lk_write, lk_exec} == $past(fill_perm)); // R2

    AST_FLUSH_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_prev && $past(flush_en) && !$past(fill_en) && lk_valid && key_now != '0
         && lk_list_id == $past(flush_list_id))
        |-> lk_fault); // R8

endmodule

bind acl_check_cache acl_check_cache_chk #(.KEYRING_W(KEYRING_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_list_id    (lk_list_id),
    .lk_keyring    (lk_keyring),
    .lk_hit        (lk_hit),
    .lk_fault      (lk_fault),
    .lk_read       (lk_read),
    .lk_write      (lk_write),
    .lk_exec       (lk_exec),
    .fill_en       (fill_en),
    .fill_list_id  (fill_list_id),
    .fill_key      (fill_key),
    .fill_perm     (fill_perm),
    .flush_en      (flush_en),
    .flush_list_id (flush_list_id)
);

// File: tb/acl_check_cache_bench.sv
module acl_check_cache_bench;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_list_id = '0;
    logic [31:0] lk_keyring = '0;
    logic        lk_hit, lk_fault, lk_read, lk_write, lk_exec;
    logic        fill_en = 1'b0;
    logic [15:0] fill_list_id = '0;
    logic [15:0] fill_key = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush_en = 1'b0;
    logic [15:0] flush_list_id = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    acl_check_cache u_acl_check_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_list_id(lk_list_id), .lk_keyring(lk_keyring),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_read(lk_read),
        .lk_write(lk_write), .lk_exec(lk_exec),
        .fill_en(fill_en), .fill_list_id(fill_list_id), .fill_key(fill_key),
        .fill_perm(fill_perm), .flush_en(flush_en), .flush_list_id(flush_list_id)
    );

    // reference model
    logic        m_v   [N];
    logic [15:0] m_id  [N];
    logic [15:0] m_key [N];
    logic [2:0]  m_perm[N];
    int          m_ptr;

    function automatic logic [4:0] expect_out(input logic [15:0] id, input logic [15:0] key);
        if (key == 16'h0) return 5'b00111;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_id[i] == id && m_key[i] == key) return {2'b10, m_perm[i]};
        return 5'b01000;
    endfunction

    task automatic model_update(input logic f, input logic [15:0] id, input logic [15:0] key,
                                input logic [2:0] perm, input logic fl, input logic [15:0] fid);
        int tgt = -1;
        logic adv = 1'b0;
        if (f) begin
            for (int i = 0; i < N; i++)
                if (tgt < 0 && m_v[i] && m_id[i] == id && m_key[i] == key) tgt = i;
            if (tgt < 0) begin
                for (int i = 0; i < N; i++)
                    if (tgt < 0 && !m_v[i]) tgt = i;
                if (tgt < 0) begin
                    tgt = m_ptr;
                    adv = 1'b1;
                end
            end
        end
        if (fl)
            for (int i = 0; i < N; i++)
                if (m_id[i] == fid) m_v[i] = 1'b0;
        if (f) begin
            m_v[tgt] = 1'b1; m_id[tgt] = id; m_key[tgt] = key; m_perm[tgt] = perm;
        end
        if (adv) m_ptr = (m_ptr + 1) % N;
    endtask

    task automatic compare(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {lk_hit, lk_fault, lk_read, lk_write, lk_exec};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s id=%h key=%h actual=%b expected=%b (hit,fault,r,w,x)",
                     tag, lk_list_id, lk_keyring[15:0], act, exp);
        end
    endtask

    // lookup in its own cycle; sampled mid-low-phase
    task automatic look(input string tag, input logic [15:0] id, input logic [15:0] key);
        @(negedge clk);
        lk_valid   = 1'b1;
        lk_list_id = id;
        lk_keyring = {16'h5A3C ^ id, key};
        #1;
        compare(tag, expect_out(id, key));
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [15:0] id, input logic [15:0] key, input logic [2:0] perm);
        @(negedge clk);
        fill_en = 1'b1; fill_list_id = id; fill_key = key; fill_perm = perm;
        @(posedge clk); #1;
        fill_en = 1'b0;
        model_update(1'b1, id, key, perm, 1'b0, 16'h0);
    endtask

    task automatic flush(input logic [15:0] id);
        @(negedge clk);
        flush_en = 1'b1; flush_list_id = id;
        @(posedge clk); #1;
        flush_en = 1'b0;
        model_update(1'b0, 16'h0, 16'h0, 3'b0, 1'b1, id);
    endtask

    task automatic sweep_pairs(input string tag);
        for (int i = 1; i <= 3; i++)
            for (int k = 1; k <= 3; k++)
                look(tag, 16'(i), 16'(k));
        look({tag, "/R4"}, 16'h0002, 16'h0000);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [4:0] old_exp;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 1'b0; m_id[i] = '0; m_key[i] = '0; m_perm[i] = '0;
        end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look("R1", 16'h0001, 16'h0001);
        look("R1", 16'h0000, 16'h0007);

        // R11: idle port quiet
        @(negedge clk);
        lk_valid = 1'b0; lk_list_id = 16'h0001; lk_keyring = 32'h0;
        #1 compare("R11", 5'b00000);

        // R2: every rights encoding in a single entry, R7 in-place rewrite
        for (int p = 0; p < 8; p++) begin
            fill(16'h0001, 16'h0001, 3'(p));
            look("R2/R7", 16'h0001, 16'h0001);
            look("R3", 16'h0001, 16'h0002);
        end
        look("R7", 16'h0002, 16'h0001);

        // R5/R6: fill to full, then round-robin eviction
        fill(16'h0001, 16'h0002, 3'b100);
        fill(16'h0001, 16'h0003, 3'b010);
        fill(16'h0002, 16'h0001, 3'b001);
        sweep_pairs("R5");
        fill(16'h0003, 16'h0003, 3'b110);
        look("R6", 16'h0001, 16'h0001);
        look("R6", 16'h0003, 16'h0003);
        fill(16'h0003, 16'h0002, 3'b011);
        look("R6", 16'h0001, 16'h0002);
        look("R6", 16'h0003, 16'h0002);

        // R8 flush, then R5 lowest free slot, then R6 pointer continues
        flush(16'h0001);
        look("R8", 16'h0001, 16'h0003);
        fill(16'h0002, 16'h0002, 3'b101);
        fill(16'h0002, 16'h0003, 3'b111);
        sweep_pairs("R5/R6");

        // R8: lookup in the flush cycle sees old contents
        @(negedge clk);
        flush_en = 1'b1; flush_list_id = 16'h0002;
        lk_valid = 1'b1; lk_list_id = 16'h0002; lk_keyring = {16'h0, 16'h0001};
        #1 compare("R8", expect_out(16'h0002, 16'h0001));
        @(posedge clk); #1;
        flush_en = 1'b0; lk_valid = 1'b0;
        model_update(1'b0, 16'h0, 16'h0, 3'b0, 1'b1, 16'h0002);
        sweep_pairs("R8");

        // R9: lookup in the fill cycle sees old contents
        @(negedge clk);
        fill_en = 1'b1; fill_list_id = 16'h0001; fill_key = 16'h0001; fill_perm = 3'b110;
        lk_valid = 1'b1; lk_list_id = 16'h0001; lk_keyring = {16'h0, 16'h0001};
        old_exp = expect_out(16'h0001, 16'h0001);
        #1 compare("R9", old_exp);
        @(posedge clk); #1;
        fill_en = 1'b0; lk_valid = 1'b0;
        model_update(1'b1, 16'h0001, 16'h0001, 3'b110, 1'b0, 16'h0);
        look("R9", 16'h0001, 16'h0001);

        // R10: fill and flush of the same list in one cycle
        fill(16'h0003, 16'h0001, 3'b001);
        @(negedge clk);
        fill_en = 1'b1; fill_list_id = 16'h0003; fill_key = 16'h0002; fill_perm = 3'b010;
        flush_en = 1'b1; flush_list_id = 16'h0003;
        @(posedge clk); #1;
        fill_en = 1'b0; flush_en = 1'b0;
        model_update(1'b1, 16'h0003, 16'h0002, 3'b010, 1'b1, 16'h0003);
        look("R10", 16'h0003, 16'h0002);
        look("R10", 16'h0003, 16'h0001);
        sweep_pairs("R10");

        // near-exhaustive mixed sweep over a 3x3 pair space
        for (int s = 0; s < 60; s++) begin
            logic [15:0] id;
            logic [15:0] key;
            id  = 16'(1 + (s * 5) % 3);
            key = 16'(1 + (s * 3 + s / 3) % 3);
            if (s % 5 == 3) flush(id);
            else fill(id, key, 3'((s * 3) % 8));
            sweep_pairs("R2/R3/R5/R6/R7/R8");
        end

        // R4: disabled key ignores cache and upper keyring bits
        fill(16'h0004, 16'h0000, 3'b000);
        look("R4", 16'h0004, 16'h0000);
        @(negedge clk);
        lk_valid = 1'b1; lk_list_id = 16'h0004; lk_keyring = 32'hFFFF_0000;
        #1 compare("R4", 5'b00111);
        lk_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule